// File: doc/BRIEF.md
# Transmit Timestamp Capture Memory

This block keeps the transmit timestamps of several network ports. Each port owns a fixed number of slots. When an outgoing packet asks for a timestamp, the transmit path raises a capture request that names a port and a slot. The block then stores the 40-bit value of that port's running timer in the slot and marks the slot valid. Packets that do not ask for a stamp never reach this block.

Software, or a bridge in front of it, reads each slot as two 32-bit words: a low word and a high word. Both words are reached through a single-cycle register port. Stamp bits cannot be written. Writing zero to a word clears that half of the stamp. The valid mark drops once both halves have been zeroed, in either order, and the slot can then take a new stamp. A request aimed at a slot that is still valid is refused, reported for one cycle, and added to a saturating drop counter.

Top module: `tx_stamp_store`

## Requirements
- R1: After reset, every slot is invalid, every low and high word reads zero, `cap_drop` is low and `drop_cnt` is zero.
- R2: A capture request to an invalid slot stores `port_time` of the named port (bits `p*40 +: 40` for port p) into that slot and sets its valid mark. Both take effect at the same clock edge that samples the request.
- R3: A capture request to a valid slot leaves the slot unchanged. It drives `cap_drop` high for exactly the cycle after the edge that sampled it, and adds one to `drop_cnt` at that same edge; `drop_cnt` stops at its maximum. `drop_cnt` never changes without a drop.
- R4: Register address layout: bit `ADDR_W-1` selects the bank (0 = low word, 1 = high word), the lowest `SLOT_W` bits give the slot index, and the port number sits in the bits between them. The low word is stamp bits 31:0. In the high word, bits 7:0 are stamp bits 39:32, bit 8 is the valid mark, and all other bits read zero.
- R5: A read is answered one cycle after `reg_rd` is sampled: `reg_ack` is high and `reg_rdata` holds the word the slot had at the sampling edge. `reg_ack` is low in every other cycle.
- R6: On a valid slot, a zero write to the low word clears stamp bits 31:0, and a zero write to the high word clears stamp bits 39:32. The valid mark clears only once both words have been zero-written since the last capture, whichever word comes first.
- R7: A write with any nonzero data changes no stamp bit and no valid mark.
- R8: A slot that has had only one of its two words zeroed is still valid, and further capture requests to it are dropped as in R3.
- R9: Once fully cleared, a slot accepts a new capture.
- R10: Captures and clears act only on the slot they address; every other slot keeps its stamp and valid mark.
- R11: When a capture and a zero write target the same invalid slot in the same cycle, the capture takes effect and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Capture request from the transmit path |
| cap_port | input | PORT_W | Port of the capture request |
| cap_slot | input | SLOT_W | Slot index of the capture request |
| port_time | input | NUM_PORTS*40 | The 40-bit timer value of each port, one field per port |
| reg_addr | input | ADDR_W | Register address {bank, port, slot} |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; only all-zero data takes effect |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, registered |
| reg_ack | output | 1 | Read data valid, one cycle after `reg_rd` |
| cap_drop | output | 1 | One-cycle pulse for a refused capture |
| drop_cnt | output | CNT_W | Saturating count of refused captures |

## Verification
Every result of this block appears one clock edge after the stimulus that causes it. A stored stamp and its valid mark, a cleared half, `cap_drop`, the `drop_cnt` step and the registered read word with `reg_ack` all follow the single edge that samples their inputs. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then samples the outputs there, half a cycle after the rising edge that acted. State that can only be seen through the read port is checked with a read that starts after the changing edge. That read is checked one edge later, so every stored result is observed exactly two edges after it was caused.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

  localparam int TS_W    = 40;
  localparam int LO_W    = 32;
  localparam int HI_W    = TS_W - LO_W;
  localparam int WORD_W  = 32;
  localparam int VLD_POS = HI_W;

  function automatic logic [WORD_W-1:0] tsx_lo_word(input logic [TS_W-1:0] st);
    return st[LO_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] tsx_hi_word(input logic vld,
                                                    input logic [TS_W-1:0] st);
    logic [WORD_W-1:0] w;
    w = '0;
    w[HI_W-1:0] = st[TS_W-1:LO_W];
    w[VLD_POS]  = vld;
    return w;
  endfunction

endpackage

// File: rtl/tsx_slot.sv
module tsx_slot
  import tsx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_we,
  input  logic [TS_W-1:0] cap_data,
  input  logic            clr_lo,
  input  logic            clr_hi,
  output logic [TS_W-1:0] stamp,
  output logic            valid
);

  logic [TS_W-1:0] stamp_q;
  logic            vld_q;
  logic            lo_zeroed_q;
  logic            hi_zeroed_q;
  logic            lo_done;
  logic            hi_done;

  assign lo_done = clr_lo | lo_zeroed_q;
  assign hi_done = clr_hi | hi_zeroed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q     <= '0;
      vld_q       <= 1'b0;
      lo_zeroed_q <= 1'b0;
      hi_zeroed_q <= 1'b0;
    end else if (cap_we) begin
      stamp_q     <= cap_data;
      vld_q       <= 1'b1;
      lo_zeroed_q <= 1'b0;
      hi_zeroed_q <= 1'b0;
    end else if (vld_q) begin
      if (clr_lo) begin
        stamp_q[LO_W-1:0] <= '0;
        lo_zeroed_q       <= 1'b1;
      end
      if (clr_hi) begin
        stamp_q[TS_W-1:LO_W] <= '0;
        hi_zeroed_q          <= 1'b1;
      end
      if (lo_done && hi_done) begin
        vld_q       <= 1'b0;
        lo_zeroed_q <= 1'b0;
        hi_zeroed_q <= 1'b0;
      end
    end
  end

  assign stamp = stamp_q;
  assign valid = vld_q;

endmodule

// File: rtl/tsx_cap_dec.sv
module tsx_cap_dec
  import tsx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SLOTS     = 8,
  parameter int PORT_W    = 2,
  parameter int SLOT_W    = 3,
  localparam int NSLOT    = NUM_PORTS * SLOTS,
  localparam int IDX_W    = PORT_W + SLOT_W
)(
  input  logic                      cap_req,
  input  logic [PORT_W-1:0]         cap_port,
  input  logic [SLOT_W-1:0]         cap_slot,
  input  logic [NUM_PORTS*TS_W-1:0] port_time,
  input  logic [NSLOT-1:0]          slot_valid,
  output logic [NSLOT-1:0]          cap_we,
  output logic [TS_W-1:0]           cap_data,
  output logic                      drop_evt
);

  localparam logic [IDX_W:0] NSLOT_V = (IDX_W+1)'(NSLOT);

  logic [IDX_W-1:0] idx;
  logic             in_rng;
  logic             hit_valid;
  logic             accept;

  assign idx       = {cap_port, cap_slot};
  assign in_rng    = ({1'b0, idx} < NSLOT_V);
  assign hit_valid = in_rng && slot_valid[idx];
  assign accept    = cap_req && in_rng && !hit_valid;
  assign drop_evt  = cap_req && hit_valid;
  assign cap_data  = port_time[int'(cap_port)*TS_W +: TS_W];

  for (genvar g = 0; g < NSLOT; g++) begin : g_we
    localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
    assign cap_we[g] = accept && (idx == SELF);
  end

endmodule

// File: rtl/tsx_wr_dec.sv
module tsx_wr_dec
  import tsx_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = IDX_W + 1
)(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [NSLOT-1:0]  clr_lo,
  output logic [NSLOT-1:0]  clr_hi
);

  logic             wr_zero;
  logic             bank_hi;
  logic [IDX_W-1:0] idx;

  assign wr_zero = reg_wr && (reg_wdata == '0);
  assign bank_hi = reg_addr[ADDR_W-1];
  assign idx     = reg_addr[IDX_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_clr
    localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
    assign clr_lo[g] = wr_zero && !bank_hi && (idx == SELF);
    assign clr_hi[g] = wr_zero &&  bank_hi && (idx == SELF);
  end

endmodule

// File: rtl/tsx_rd_port.sv
module tsx_rd_port
  import tsx_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = IDX_W + 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NSLOT-1:0]      slot_valid,
  input  logic [NSLOT*TS_W-1:0] stamp_flat,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  reg_ack
);

  localparam logic [IDX_W:0] NSLOT_V = (IDX_W+1)'(NSLOT);

  logic [IDX_W-1:0]  idx;
  logic              in_rng;
  logic [TS_W-1:0]   st_sel;
  logic              vld_sel;
  logic [WORD_W-1:0] word_nxt;

  assign idx     = reg_addr[IDX_W-1:0];
  assign in_rng  = ({1'b0, idx} < NSLOT_V);
  assign st_sel  = stamp_flat[int'(idx)*TS_W +: TS_W];
  assign vld_sel = slot_valid[idx];

  always_comb begin
    if (!in_rng)
      word_nxt = '0;
    else if (reg_addr[ADDR_W-1])
      word_nxt = tsx_hi_word(vld_sel, st_sel);
    else
      word_nxt = tsx_lo_word(st_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_ack   <= 1'b0;
    end else begin
      reg_ack <= reg_rd;
      if (reg_rd) reg_rdata <= word_nxt;
    end
  end

endmodule

// File: rtl/tsx_drop_ctr.sv
module tsx_drop_ctr #(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_evt,
  output logic             cap_drop,
  output logic [CNT_W-1:0] drop_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_drop <= 1'b0;
      drop_cnt <= '0;
    end else begin
      cap_drop <= drop_evt;
      if (drop_evt && drop_cnt != CNT_MAX) drop_cnt <= drop_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tx_stamp_store.sv
module tx_stamp_store
  import tsx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IDX_W    = PORT_W + SLOT_W,
  localparam int ADDR_W   = IDX_W + 1,
  localparam int NSLOT    = NUM_PORTS * SLOTS
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_req,
  input  logic [PORT_W-1:0]         cap_port,
  input  logic [SLOT_W-1:0]         cap_slot,
  input  logic [NUM_PORTS*TS_W-1:0] port_time,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [WORD_W-1:0]         reg_wdata,
  input  logic                      reg_rd,
  output logic [WORD_W-1:0]         reg_rdata,
  output logic                      reg_ack,
  output logic                      cap_drop,
  output logic [CNT_W-1:0]          drop_cnt
);

  // Named internal events, also observed by the bound checker
  logic [NSLOT-1:0]      slot_valid;
  logic [NSLOT-1:0]      cap_we;
  logic [NSLOT-1:0]      clr_lo;
  logic [NSLOT-1:0]      clr_hi;
  logic [NSLOT*TS_W-1:0] stamp_flat;
  logic [TS_W-1:0]       cap_data;
  logic                  drop_evt;

  tsx_cap_dec #(
    .NUM_PORTS(NUM_PORTS), .SLOTS(SLOTS), .PORT_W(PORT_W), .SLOT_W(SLOT_W)
  ) u_cap (
    .cap_req(cap_req), .cap_port(cap_port), .cap_slot(cap_slot),
    .port_time(port_time), .slot_valid(slot_valid),
    .cap_we(cap_we), .cap_data(cap_data), .drop_evt(drop_evt)
  );

  tsx_wr_dec #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_wr (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .clr_lo(clr_lo), .clr_hi(clr_hi)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    tsx_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .cap_we(cap_we[s]), .cap_data(cap_data),
      .clr_lo(clr_lo[s]), .clr_hi(clr_hi[s]),
      .stamp(stamp_flat[s*TS_W +: TS_W]), .valid(slot_valid[s])
    );
  end

  tsx_rd_port #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .slot_valid(slot_valid), .stamp_flat(stamp_flat),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack)
  );

  tsx_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt),
    .cap_drop(cap_drop), .drop_cnt(drop_cnt)
  );

endmodule

// File: rtl/tx_stamp_store_chk.sv
module tx_stamp_store_chk
  import tsx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IDX_W    = PORT_W + SLOT_W,
  localparam int NSLOT    = NUM_PORTS * SLOTS
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_req,
  input logic [PORT_W-1:0] cap_port,
  input logic [SLOT_W-1:0] cap_slot,
  input logic              reg_wr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              reg_rd,
  input logic              reg_ack,
  input logic              cap_drop,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic [NSLOT-1:0]  slot_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W:0]   NSLOT_V = (IDX_W+1)'(NSLOT);

  logic [IDX_W-1:0] cidx;
  logic             c_rng;
  assign cidx  = {cap_port, cap_slot};
  assign c_rng = ({1'b0, cidx} < NSLOT_V);

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && c_rng && slot_valid[cidx] |=> cap_drop); // R3

  AST_NO_DROP_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && c_rng && !slot_valid[cidx] |=> !cap_drop); // R9

  AST_IDLE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req |=> !cap_drop); // R3

  AST_CAPTURE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && c_rng && !slot_valid[cidx] |=> slot_valid[$past(cidx)]); // R2

  AST_VALID_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & ~$past(slot_valid)) != '0 |-> $past(cap_req)); // R2

  AST_VALID_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid & ~$past(slot_valid)) <= 1); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_drop && $past(drop_cnt) != CNT_MAX |-> drop_cnt == $past(drop_cnt) + 1'b1); // R3

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_drop |-> $stable(drop_cnt)); // R3

  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_ack); // R5

  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_ack); // R5

  AST_NONZERO_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata != '0 |=> ($past(slot_valid) & ~slot_valid) == '0); // R7

  AST_VALID_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_valid) & ~slot_valid) != '0 |-> $past(reg_wr) && $past(reg_wdata) == '0); // R6

endmodule

bind tx_stamp_store tx_stamp_store_chk #(
  .NUM_PORTS(NUM_PORTS), .SLOTS(SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_port(cap_port),
  .cap_slot(cap_slot), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rd(reg_rd), .reg_ack(reg_ack), .cap_drop(cap_drop),
  .drop_cnt(drop_cnt), .slot_valid(slot_valid)
);

// File: tb/sim_tx_stamp_store.sv
module sim_tx_stamp_store;

  localparam int NP = 4;
  localparam int SL = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_req = 1'b0;
  logic [1:0]    cap_port = '0;
  logic [2:0]    cap_slot = '0;
  logic [NP*40-1:0] port_time = '0;
  logic [5:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [31:0]   reg_rdata;
  logic          reg_ack;
  logic          cap_drop;
  logic [CW-1:0] drop_cnt;

  int errors = 0;
  int checks = 0;
  int exp_drops = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_stamp_store #(.NUM_PORTS(NP), .SLOTS(SL), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_port(cap_port),
    .cap_slot(cap_slot), .port_time(port_time), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack), .cap_drop(cap_drop),
    .drop_cnt(drop_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 address layout: {bank, port[1:0], slot[2:0]}
  function automatic logic [5:0] mk_addr(input logic bank, input int p, input int s);
    return {bank, 2'(p), 3'(s)};
  endfunction

  function automatic logic [31:0] hi_exp(input logic v, input logic [39:0] st);
    return {23'd0, v, st[39:32]};
  endfunction

  task automatic rd_word(input string req, input logic bank, input int p, input int s,
                         input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = mk_addr(bank, p, s);
    @(negedge clk);
    reg_rd = 1'b0;
    chk({req, " ack"}, 64'(reg_ack), 64'd1);
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wr_word(input logic bank, input int p, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = mk_addr(bank, p, s); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic capture(input string req, input int p, input int s,
                         input logic [39:0] t, input bit expect_drop);
    @(negedge clk);
    port_time[p*40 +: 40] = t;
    cap_req = 1'b1; cap_port = 2'(p); cap_slot = 3'(s);
    @(negedge clk);
    cap_req = 1'b0;
    if (expect_drop) exp_drops++;
    chk({req, " cap_drop"}, 64'(cap_drop), 64'(expect_drop));
    chk({req, " drop_cnt"}, 64'(drop_cnt), 64'(exp_drops));
  endtask

  task automatic t_reset;
    chk("R1 cap_drop", 64'(cap_drop), 64'd0);
    chk("R1 drop_cnt", 64'(drop_cnt), 64'd0);
    chk("R5 idle ack", 64'(reg_ack), 64'd0);
    rd_word("R1 lo p0s0", 1'b0, 0, 0, 32'd0);
    rd_word("R1 hi p3s7", 1'b1, 3, 7, 32'd0);
    rd_word("R1 hi p1s2", 1'b1, 1, 2, 32'd0);
  endtask

  task automatic t_capture;
    port_time[0 +: 40] = 40'h11_2222_3333;
    capture("R2", 2, 5, 40'h98_7654_3210, 1'b0);
    rd_word("R2 R4 lo", 1'b0, 2, 5, 32'h7654_3210);
    rd_word("R2 R4 hi", 1'b1, 2, 5, hi_exp(1'b1, 40'h98_7654_3210));
    @(negedge clk);
    chk("R5 ack drops", 64'(reg_ack), 64'd0);
  endtask

  task automatic t_overflow;
    capture("R3", 2, 5, 40'h01_0101_0101, 1'b1);
    @(negedge clk);
    chk("R3 pulse ends", 64'(cap_drop), 64'd0);
    rd_word("R3 lo kept", 1'b0, 2, 5, 32'h7654_3210);
    rd_word("R3 hi kept", 1'b1, 2, 5, hi_exp(1'b1, 40'h98_7654_3210));
  endtask

  task automatic t_nonzero_write;
    wr_word(1'b0, 2, 5, 32'h0000_0001);
    wr_word(1'b1, 2, 5, 32'h8000_0000);
    rd_word("R7 lo", 1'b0, 2, 5, 32'h7654_3210);
    rd_word("R7 hi", 1'b1, 2, 5, hi_exp(1'b1, 40'h98_7654_3210));
  endtask

  task automatic t_clear_hi_first;
    wr_word(1'b1, 2, 5, 32'd0);
    rd_word("R6 hi half", 1'b1, 2, 5, hi_exp(1'b1, 40'h0));
    rd_word("R6 lo kept", 1'b0, 2, 5, 32'h7654_3210);
    capture("R8", 2, 5, 40'hAA_AAAA_AAAA, 1'b1);
    wr_word(1'b0, 2, 5, 32'd0);
    rd_word("R6 lo zero", 1'b0, 2, 5, 32'd0);
    rd_word("R6 invalid", 1'b1, 2, 5, 32'd0);
  endtask

  task automatic t_recapture;
    capture("R9", 2, 5, 40'h5A_C0DE_F00D, 1'b0);
    rd_word("R9 lo", 1'b0, 2, 5, 32'hC0DE_F00D);
    rd_word("R9 hi", 1'b1, 2, 5, hi_exp(1'b1, 40'h5A_C0DE_F00D));
  endtask

  task automatic t_independence;
    capture("R10 a", 0, 0, 40'h12_3456_789A, 1'b0);
    capture("R10 b", 3, 7, 40'hFE_DCBA_9876, 1'b0);
    wr_word(1'b0, 0, 0, 32'd0);
    wr_word(1'b1, 0, 0, 32'd0);
    rd_word("R6 lo-first invalid", 1'b1, 0, 0, 32'd0);
    rd_word("R10 b lo", 1'b0, 3, 7, 32'hDCBA_9876);
    rd_word("R10 b hi", 1'b1, 3, 7, hi_exp(1'b1, 40'hFE_DCBA_9876));
    rd_word("R10 p2s5 hi", 1'b1, 2, 5, hi_exp(1'b1, 40'h5A_C0DE_F00D));
    rd_word("R10 p0s1 hi", 1'b1, 0, 1, 32'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    port_time[40 +: 40] = 40'h77_1234_5678;
    cap_req = 1'b1; cap_port = 2'd1; cap_slot = 3'd3;
    reg_wr = 1'b1; reg_addr = mk_addr(1'b0, 1, 3); reg_wdata = '0;
    @(negedge clk);
    cap_req = 1'b0; reg_wr = 1'b0;
    chk("R11 no drop", 64'(cap_drop), 64'd0);
    rd_word("R11 lo", 1'b0, 1, 3, 32'h1234_5678);
    rd_word("R11 hi", 1'b1, 1, 3, hi_exp(1'b1, 40'h77_1234_5678));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_overflow();
    t_nonzero_write();
    t_clear_hi_first();
    t_recapture();
    t_independence();
    t_same_cycle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule